// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a 64-bit time-of-day value counted in nanoseconds, for use as the reference clock of a precision time protocol stamping path. The count has no separate seconds field. On each clock edge where counting is allowed, the block adds a fixed-point increment to the count. The increment has an integer nanosecond part and a 32-bit binary fraction. A hidden 32-bit fraction accumulator sits below the visible nanoseconds, so a clock whose period is not a whole number of nanoseconds still tracks real time closely over many ticks.

Software reaches the block through a small 32-bit register port. Values wider than one word are transferred through side effects, so that each transfer stays consistent:
- A read of the low time word freezes the upper half, and a later read of the high word returns that frozen half.
- Writes to the low word of the time or of the increment are only staged. The full value takes effect when the matching high word is written.

Until software commits an increment of its own, the block picks a default increment from the link-speed input. At the unsupported slowest speed, the block stops the count.

Top module: `ptp_ns_clock`

## Requirements
- R1: After reset, the time is 0 and the control register reads 0 (enable bit 0 clear, override bit 1 clear). The increment registers show the default for the current link speed.
- R2: While enabled, each clock adds the increment to the 96-bit value {nanoseconds, fraction}. The carry out of the fraction enters the nanoseconds on the same edge. Starting from a load, after N ticks the nanoseconds equal the load value plus floor(N × increment / 2^32).
- R3: While the enable bit is clear, the time and the fraction hold their values.
- R4: The default increment follows link_speed. Codes 0 (no link), 4 and 5 to 7 select 0x01_9999_9999 (1.6 ns). Code 3 selects 0x03_3333_3333 (3.2 ns). Code 2 selects 0x20_0000_0000 (32 ns). Code 1 reports 0.
- R5: With link_speed code 1, the slowest and unsupported speed, the time does not advance even when enabled.
- R6: A read of the time low word (address 1) returns the live low half and captures the live high half on that edge. A read of the time high word (address 2) returns the captured half.
- R7: A write to address 1 only stages the low word. A write to address 2 loads {written word, staged low word} into the time and clears the fraction. On the same edge, this load wins over a tick.
- R8: A write to address 3 stages the increment fraction. A write to address 4 commits {bits INT_W-1:0 of the written word, staged fraction} as the increment and sets the override bit. Addresses 3 and 4 read back the increment in effect. A control write (address 0, bit 0 enable, bit 1 override) with bit 1 clear returns to the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_speed | input | 3 | Link speed code selecting the default increment |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (its side effects happen on the clock edge) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
Two events can fall on the same clock edge: a time load from a high-word write, and a counting tick. The bench commits a new time while the counter is running. It then reads the low word before the next edge and expects exactly the loaded value, not the loaded value plus an increment. Two more enabled edges follow, and the bench expects the load value plus floor(2 × increment / 2^32). That result only holds if the load also cleared the fraction accumulator that the earlier ticks had left dirty.

// File: rtl/ptp_ns_clock.sv
module ptp_ns_clock #(
  parameter int INT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  link_speed,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int DW     = 32;
  localparam int FRAC_W = DW;
  localparam int NS_W   = 2 * DW;
  localparam int INC_W  = INT_W + FRAC_W;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TLO  = 3'd1;
  localparam logic [2:0] A_THI  = 3'd2;
  localparam logic [2:0] A_ILO  = 3'd3;
  localparam logic [2:0] A_IHI  = 3'd4;

  localparam logic [2:0] LS_NONE = 3'd0;
  localparam logic [2:0] LS_STOP = 3'd1;
  localparam logic [2:0] LS_LOW  = 3'd2;
  localparam logic [2:0] LS_MID  = 3'd3;

  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic              en_q, ovr_q;
  logic [DW-1:0]     stage_lo, snap_hi, inc_lo_stage;
  logic [INC_W-1:0]  sw_inc, def_inc, eff_inc;
  logic [FRAC_W-1:0] frac_sum;
  logic              carry;
  logic              stall, tick;
  logic              wr_ctrl, wr_tlo, wr_thi, wr_ilo, wr_ihi, rd_tlo;
  logic [NS_W-1:0]   ns_next;
  logic              unused_wbits;

  always_comb begin
    case (link_speed)
      LS_NONE: def_inc = {INT_W'(1),    32'h9999_9999};
      LS_STOP: def_inc = '0;
      LS_LOW:  def_inc = {INT_W'(32),   32'h0000_0000};
      LS_MID:  def_inc = {INT_W'(3),    32'h3333_3333};
      default: def_inc = {INT_W'(1),    32'h9999_9999};
    endcase
  end

  assign eff_inc = ovr_q ? sw_inc : def_inc;
  assign stall   = (link_speed == LS_STOP);
  assign tick    = en_q && !stall;

  assign {carry, frac_sum} = {1'b0, frac_q} + {1'b0, eff_inc[FRAC_W-1:0]};
  assign ns_next = ns_q + NS_W'(eff_inc[INC_W-1:FRAC_W]) + NS_W'(carry);

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_tlo  = reg_wr && (reg_addr == A_TLO);
  assign wr_thi  = reg_wr && (reg_addr == A_THI);
  assign wr_ilo  = reg_wr && (reg_addr == A_ILO);
  assign wr_ihi  = reg_wr && (reg_addr == A_IHI);
  assign rd_tlo  = reg_rd && (reg_addr == A_TLO);

  assign unused_wbits = ^reg_wdata[DW-1:INT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (wr_thi) begin
      ns_q   <= {reg_wdata, stage_lo};
      frac_q <= '0;
    end else if (tick) begin
      ns_q   <= ns_next;
      frac_q <= frac_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      ovr_q        <= 1'b0;
      stage_lo     <= '0;
      snap_hi      <= '0;
      inc_lo_stage <= '0;
      sw_inc       <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[0];
        ovr_q <= reg_wdata[1];
      end else if (wr_ihi) begin
        ovr_q <= 1'b1;
      end
      if (wr_tlo) stage_lo <= reg_wdata;
      if (rd_tlo) snap_hi <= ns_q[NS_W-1:DW];
      if (wr_ilo) inc_lo_stage <= reg_wdata;
      if (wr_ihi) sw_inc <= {reg_wdata[INT_W-1:0], inc_lo_stage};
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {30'd0, ovr_q, en_q};
      A_TLO:   reg_rdata = ns_q[DW-1:0];
      A_THI:   reg_rdata = snap_hi;
      A_ILO:   reg_rdata = eff_inc[FRAC_W-1:0];
      A_IHI:   reg_rdata = DW'(eff_inc[INC_W-1:FRAC_W]);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptp_ns_clock_chk.sv
module ptp_ns_clock_chk #(
  parameter int INT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          link_speed,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [2:0]          reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [63:0]         ns_q,
  input logic [31:0]         frac_q,
  input logic                en_q,
  input logic [31:0]         snap_hi,
  input logic [31:0]         stage_lo,
  input logic [31:0]         inc_lo_stage,
  input logic [INT_W+31:0]   sw_inc
);
  logic load;
  assign load = reg_wr && (reg_addr == 3'd2);

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ns_q == {$past(reg_wdata), $past(stage_lo)}) && (frac_q == '0));

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load) |=> ($stable(ns_q) && $stable(frac_q)));

  assert_stop_slowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_speed == 3'd1 && !load) |=> $stable(ns_q));

  assert_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && link_speed != 3'd1 && !load) |=> (ns_q > $past(ns_q)));

  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd1) |=> (snap_hi == $past(ns_q[63:32])));

  assert_inc_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4) |=> (sw_inc == {$past(reg_wdata[INT_W-1:0]), $past(inc_lo_stage)}));
endmodule

bind ptp_ns_clock ptp_ns_clock_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_speed(link_speed), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ns_q(ns_q), .frac_q(frac_q), .en_q(en_q), .snap_hi(snap_hi),
  .stage_lo(stage_lo), .inc_lo_stage(inc_lo_stage), .sw_inc(sw_inc)
);

// File: tb/tb_ptp_ns_clock.sv
module tb_ptp_ns_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  link_speed = 3'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [39:0] INC16 = 40'h01_9999_9999;
  localparam logic [39:0] INC32 = 40'h03_3333_3333;

  ptp_ns_clock dut (.clk(clk), .rst_n(rst_n), .link_speed(link_speed), .reg_wr(reg_wr),
                    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
                    .reg_rdata(reg_rdata));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    t = {hi, lo};
  endtask

  task automatic load_time(input logic [63:0] t);
    wr(3'd1, t[31:0]);
    wr(3'd2, t[63:32]);
  endtask

  task automatic run_ticks(input int n);
    wr(3'd0, 32'd1);
    repeat (n - 1) @(negedge clk);
    wr(3'd0, 32'd0);
  endtask

  function automatic logic [63:0] expect_ns(input logic [63:0] base, input int n, input logic [39:0] inc);
    logic [127:0] p;
    p = 128'(n) * 128'(inc);
    return base + p[95:32];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    logic [63:0] t;
    rd(3'd0, d); check("R1 ctrl", 64'(d), 64'd0);
    read_time(t); check("R1 time", t, 64'd0);
    rd(3'd3, d); check("R1 inc frac", 64'(d), 64'h9999_9999);
    rd(3'd4, d); check("R1 inc int", 64'(d), 64'd1);
  endtask

  task automatic t_defaults;
    logic [31:0] d;
    link_speed = 3'd2; #1;
    rd(3'd4, d); check("R4 32ns int", 64'(d), 64'h20);
    rd(3'd3, d); check("R4 32ns frac", 64'(d), 64'h0);
    link_speed = 3'd3; #1;
    rd(3'd4, d); check("R4 3.2ns int", 64'(d), 64'h3);
    rd(3'd3, d); check("R4 3.2ns frac", 64'(d), 64'h3333_3333);
    link_speed = 3'd4; #1;
    rd(3'd3, d); check("R4 top frac", 64'(d), 64'h9999_9999);
    link_speed = 3'd1; #1;
    rd(3'd4, d); check("R4 slowest int", 64'(d), 64'h0);
    link_speed = 3'd0;
  endtask

  task automatic t_count;
    logic [63:0] t;
    load_time(64'd0); run_ticks(1000); read_time(t);
    check("R2 1000 ticks 1.6ns", t, expect_ns(64'd0, 1000, INC16));
    load_time(64'd50); run_ticks(5); read_time(t);
    check("R2 5 ticks carry edge", t, expect_ns(64'd50, 5, INC16));
    link_speed = 3'd3;
    load_time(64'd0); run_ticks(7); read_time(t);
    check("R2 7 ticks 3.2ns", t, expect_ns(64'd0, 7, INC32));
    link_speed = 3'd0;
  endtask

  task automatic t_hold;
    logic [63:0] a, b;
    read_time(a);
    repeat (20) @(negedge clk);
    read_time(b);
    check("R3 hold when disabled", b, a);
  endtask

  task automatic t_slow;
    logic [63:0] a, b;
    link_speed = 3'd1;
    read_time(a);
    wr(3'd0, 32'd1);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'd0);
    read_time(b);
    check("R5 stopped at slowest", b, a);
    link_speed = 3'd0;
  endtask

  task automatic t_snapshot;
    logic [31:0] lo, hi;
    load_time(64'h1_FFFF_FFF0);
    wr(3'd0, 32'd1);
    rd(3'd1, lo);
    repeat (20) @(negedge clk);
    rd(3'd2, hi); check("R6 captured high", 64'(hi), 64'h1);
    rd(3'd1, lo);
    rd(3'd2, hi); check("R6 recaptured high", 64'(hi), 64'h2);
    wr(3'd0, 32'd0);
  endtask

  task automatic t_stage;
    logic [63:0] t;
    load_time(64'd10);
    wr(3'd1, 32'hABCD_0000);
    repeat (5) @(negedge clk);
    read_time(t); check("R7 low write staged", t, 64'd10);
    wr(3'd2, 32'd5);
    read_time(t); check("R7 commit both halves", t, 64'h5_ABCD_0000);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    logic [63:0] t;
    wr(3'd0, 32'd1);
    repeat (13) @(negedge clk);
    wr(3'd1, 32'd100);
    wr(3'd2, 32'd0);
    reg_rd = 1'b1; reg_addr = 3'd1;
    #1 d = reg_rdata;
    check("R7 load wins over tick", 64'(d), 64'd100);
    @(negedge clk);
    reg_rd = 1'b0;
    wr(3'd0, 32'd0);
    read_time(t);
    check("R7 fraction cleared by load", t, expect_ns(64'd100, 2, INC16));
  endtask

  task automatic t_inc;
    logic [31:0] d;
    logic [63:0] t;
    wr(3'd3, 32'h0);
    rd(3'd3, d); check("R8 frac only staged", 64'(d), 64'h9999_9999);
    wr(3'd4, 32'h2);
    rd(3'd4, d); check("R8 int committed", 64'(d), 64'h2);
    rd(3'd3, d); check("R8 frac committed", 64'(d), 64'h0);
    rd(3'd0, d); check("R8 override bit", 64'(d), 64'h2);
    load_time(64'd0);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd3;
    @(negedge clk); reg_wr = 1'b0;
    repeat (9) @(negedge clk);
    wr(3'd0, 32'd2);
    read_time(t); check("R8 ticks with sw inc", t, 64'd20);
    wr(3'd0, 32'd0);
    rd(3'd4, d); check("R8 back to default", 64'(d), 64'h1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_count();
    t_hold();
    t_slow();
    t_snapshot();
    t_stage();
    t_collide();
    t_inc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule